// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Private Result Pair

This block performs 32-bit multiplication and division over many clock cycles, beside an integer pipeline. A command carries one of four operations and two operands. Each multiply produces a double-width product and each divide produces a quotient and a remainder. The result is written into a pair of private result registers: an upper half (HI) and a lower half (LO). Software reaches those registers only through two dedicated read ports. No operation raises an overflow or an error, and a zero divisor also yields defined values.

The unit accepts one command at a time. The command side is a valid/ready channel. `cmd_ready` is high exactly when the unit is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A producer that sees `cmd_ready` low keeps its command stable and waits. Each read port works as a request/acknowledge pair. The requester raises its request and holds it until the acknowledge appears, and the data is valid in the cycle the acknowledge is high. Acknowledges are held off while an operation is in flight, so a move-from read never returns a stale half-result.

Inside the unit, signed operations are reduced to unsigned magnitudes. One iterative engine then runs either a shift-add multiply or a restoring divide, one bit per cycle. A final stage applies the result signs and writes HI and LO.

Top module: `muldiv_unit`

## Requirements
- R1: After synchronous reset, `busy` is low, `cmd_ready` is high, and both HI and LO read back as zero.
- R2: Op code 2'b01 (unsigned multiply) writes the upper 32 bits of the 64-bit unsigned product to HI and the lower 32 bits to LO.
- R3: Op code 2'b00 (signed multiply) writes the 64-bit two's-complement product, split the same way as in R2.
- R4: Op code 2'b11 (unsigned divide) writes the quotient to LO and the remainder to HI.
- R5: Op code 2'b10 (signed divide) truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives LO = 32'h8000_0000 and HI = 0.
- R6: With a zero divisor, HI equals the dividend. For unsigned divide, LO is all ones. For signed divide, LO is all ones when the dividend is non-negative and 1 when it is negative.
- R7: `cmd_ready` equals the inverse of `busy`. After a command is accepted, `busy` is high for exactly 33 consecutive cycles (WIDTH+1).
- R8: A command offered while `busy` is high is not accepted and does not change the result of the operation in flight.
- R9: A read request is acknowledged only in cycles where `busy` is low. In such a cycle the acknowledge is high together with the request, and the data equals the register's content.
- R10: HI and LO keep their values between completions, so repeated reads return the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can take a command (idle) |
| cmd_op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| cmd_a | input | 32 | Multiplicand / dividend |
| cmd_b | input | 32 | Multiplier / divisor |
| busy | output | 1 | Operation in flight |
| hi_rd_req | input | 1 | Request to read HI |
| hi_rd_ack | output | 1 | HI read granted this cycle |
| hi_rd_data | output | 32 | HI contents |
| lo_rd_req | input | 1 | Request to read LO |
| lo_rd_ack | output | 1 | LO read granted this cycle |
| lo_rd_data | output | 32 | LO contents |

## Verification
The hardest situations to reach are the sign-fix corners. These are the most negative operand in signed multiply and divide, -2^31 divided by -1, and a zero divisor in both signed and unsigned form. Uniform random operands almost never produce them. The stimulus therefore draws each operand from a weighted pool that includes 0, 1, all ones, 32'h8000_0000 and 32'h7FFF_FFFF alongside fully random words. It also applies directed cases for each of these corners. A second hard-to-reach situation is a command or read request arriving during the busy window. The bench deliberately offers a conflicting command and read requests while an operation is still running.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } md_op_e;

  function automatic logic op_is_div(md_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_signed(md_op_e op);
    return ~op[0];
  endfunction
endpackage

// File: rtl/md_operand_prep.sv
module md_operand_prep
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  md_op_e       op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_main,
  output logic         neg_rem
);
  logic sgn, a_neg, b_neg;

  always_comb begin
    sgn      = op_is_signed(op);
    a_neg    = sgn & opa[W-1];
    b_neg    = sgn & opb[W-1];
    mag_a    = a_neg ? (~opa + 1'b1) : opa;
    mag_b    = b_neg ? (~opb + 1'b1) : opb;
    // product / quotient sign
    neg_main = a_neg ^ b_neg;
    // remainder follows the dividend
    neg_rem  = op_is_div(op) & a_neg;
  end

  always_comb begin
    if (!sgn) assert_unsigned_passthru_R2: assert (mag_a == opa && mag_b == opb);
  end
endmodule

// File: rtl/md_iter_core.sv
module md_iter_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         div_mode,
  input  logic [W-1:0] mag_a,
  input  logic [W-1:0] mag_b,
  output logic         active,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi_q, lo_q, opnd_q;
  logic          div_q;
  logic [CW-1:0] cnt;

  logic [W:0]    mul_sum, shifted, diff;
  logic          take;
  logic [W-1:0]  hi_n, lo_n;

  always_comb begin
    mul_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, opnd_q} : '0);
    shifted = {hi_q, lo_q[W-1]};
    diff    = shifted - {1'b0, opnd_q};
    take    = ~diff[W];
    if (div_q) begin
      hi_n = take ? diff[W-1:0] : shifted[W-1:0];
      lo_n = {lo_q[W-2:0], take};
    end else begin
      hi_n = mul_sum[W:1];
      lo_n = {mul_sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      opnd_q <= '0;
      div_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        hi_q   <= '0;
        lo_q   <= mag_a;
        opnd_q <= mag_b;
        div_q  <= div_mode;
      end else if (active) begin
        hi_q <= hi_n;
        lo_q <= lo_n;
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  assign res_hi = hi_q;
  assign res_lo = lo_q;

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= LAST));
  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!active && $past(active)));
  assert_divzero_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (active && div_q && opnd_q == '0) |=> lo_q[0]);
endmodule

// File: rtl/md_result_fix.sv
module md_result_fix #(
  parameter int W = 32
) (
  input  logic         div_mode,
  input  logic         neg_main,
  input  logic         neg_rem,
  input  logic [W-1:0] raw_hi,
  input  logic [W-1:0] raw_lo,
  output logic [W-1:0] fix_hi,
  output logic [W-1:0] fix_lo
);
  localparam int DW = 2 * W;
  logic [DW-1:0] prod;

  always_comb begin
    prod = {raw_hi, raw_lo};
    if (neg_main) prod = ~prod + 1'b1;
    if (div_mode) begin
      fix_lo = neg_main ? (~raw_lo + 1'b1) : raw_lo;
      fix_hi = neg_rem  ? (~raw_hi + 1'b1) : raw_hi;
    end else begin
      fix_hi = prod[DW-1:W];
      fix_lo = prod[W-1:0];
    end
  end
endmodule

// File: rtl/md_read_port.sv
module md_read_port #(
  parameter int W = 32
) (
  input  logic         unit_busy,
  input  logic         req,
  input  logic [W-1:0] reg_val,
  output logic         ack,
  output logic [W-1:0] data
);
  assign ack  = req & ~unit_busy;
  assign data = reg_val;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [WIDTH-1:0] cmd_a,
  input  logic [WIDTH-1:0] cmd_b,
  output logic             busy,
  input  logic             hi_rd_req,
  output logic             hi_rd_ack,
  output logic [WIDTH-1:0] hi_rd_data,
  input  logic             lo_rd_req,
  output logic             lo_rd_ack,
  output logic [WIDTH-1:0] lo_rd_data
);
  localparam int NPORT = 2;

  md_op_e           op_in;
  logic             accept;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic             neg_main_c, neg_rem_c;
  logic             neg_main_q, neg_rem_q, div_q;
  logic             core_active, core_done;
  logic [WIDTH-1:0] raw_hi, raw_lo, fix_hi, fix_lo;
  logic [WIDTH-1:0] hi_q, lo_q;

  assign op_in     = md_op_e'(cmd_op);
  assign busy      = core_active | core_done;
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;

  md_operand_prep #(.W(WIDTH)) u_prep (
    .op(op_in), .opa(cmd_a), .opb(cmd_b),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_main(neg_main_c), .neg_rem(neg_rem_c)
  );

  md_iter_core #(.W(WIDTH)) u_core (
    .clk(clk), .rst(rst), .start(accept), .div_mode(op_is_div(op_in)),
    .mag_a(mag_a), .mag_b(mag_b),
    .active(core_active), .done(core_done),
    .res_hi(raw_hi), .res_lo(raw_lo)
  );

  md_result_fix #(.W(WIDTH)) u_fix (
    .div_mode(div_q), .neg_main(neg_main_q), .neg_rem(neg_rem_q),
    .raw_hi(raw_hi), .raw_lo(raw_lo),
    .fix_hi(fix_hi), .fix_lo(fix_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_main_q <= 1'b0;
      neg_rem_q  <= 1'b0;
      div_q      <= 1'b0;
      hi_q       <= '0;
      lo_q       <= '0;
    end else begin
      if (accept) begin
        neg_main_q <= neg_main_c;
        neg_rem_q  <= neg_rem_c;
        div_q      <= op_is_div(op_in);
      end
      if (core_done) begin
        hi_q <= fix_hi;
        lo_q <= fix_lo;
      end
    end
  end

  logic [NPORT-1:0] req_v, ack_v;
  logic [WIDTH-1:0] val_v  [NPORT];
  logic [WIDTH-1:0] data_v [NPORT];

  assign req_v    = {lo_rd_req, hi_rd_req};
  assign val_v[0] = hi_q;
  assign val_v[1] = lo_q;

  for (genvar g = 0; g < NPORT; g++) begin : g_rd
    md_read_port #(.W(WIDTH)) u_port (
      .unit_busy(busy), .req(req_v[g]), .reg_val(val_v[g]),
      .ack(ack_v[g]), .data(data_v[g])
    );
  end

  assign hi_rd_ack  = ack_v[0];
  assign lo_rd_ack  = ack_v[1];
  assign hi_rd_data = data_v[0];
  assign lo_rd_data = data_v[1];

  assert_accept_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);
  assert_hold_between_ops_R10: assert property (@(posedge clk) disable iff (rst)
    !core_done |=> ($stable(hi_q) && $stable(lo_q)));
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (core_active && $past(core_active)) |-> $stable(neg_main_q));
endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, cmd_ready, busy;
  logic [1:0] cmd_op;
  logic [W-1:0] cmd_a, cmd_b;
  logic hi_rd_req, hi_rd_ack, lo_rd_req, lo_rd_ack;
  logic [W-1:0] hi_rd_data, lo_rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  muldiv_unit #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .hi_rd_req(hi_rd_req), .hi_rd_ack(hi_rd_ack), .hi_rd_data(hi_rd_data),
    .lo_rd_req(lo_rd_req), .lo_rd_ack(lo_rd_ack), .lo_rd_data(lo_rd_data)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b,
                                output logic [W-1:0] eh, output logic [W-1:0] el);
    longint sa, sb, q, r;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      2'b01: begin p = {32'd0, a} * {32'd0, b}; eh = p[63:32]; el = p[31:0]; end
      2'b00: begin p = 64'(sa * sb); eh = p[63:32]; el = p[31:0]; end
      2'b11: begin
        if (b == 0) begin eh = a; el = '1; end
        else begin eh = a % b; el = a / b; end
      end
      default: begin
        if (b == 0) begin eh = a; el = a[W-1] ? 32'd1 : '1; end
        else begin
          q = sa / sb; r = sa % sb;
          eh = r[31:0]; el = q[31:0];
        end
      end
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] op, input logic [W-1:0] b);
    if (op[1] && b == 0) return "R6";
    case (op)
      2'b01: return "R2";
      2'b00: return "R3";
      2'b11: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic read_both(input string tag, input logic [W-1:0] eh,
                           input logic [W-1:0] el);
    @(negedge clk);
    hi_rd_req = 1'b1; lo_rd_req = 1'b1;
    #1;
    check(hi_rd_ack && lo_rd_ack, {tag, "_r9_ack"}, {hi_rd_ack, lo_rd_ack}, 2'b11);
    check(hi_rd_data == eh, {tag, "_hi"}, hi_rd_data, eh);
    check(lo_rd_data == el, {tag, "_lo"}, lo_rd_data, el);
    hi_rd_req = 1'b0; lo_rd_req = 1'b0;
  endtask

  // Issue one op; optionally poke a conflicting command and reads mid-flight.
  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit poke);
    logic [W-1:0] eh, el;
    int cyc;
    model(op, a, b, eh, el);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    check(cmd_ready == 1'b1, "R7_ready_idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (busy) begin
      check(cmd_ready == 1'b0, "R7_ready_inv", cmd_ready, 0);
      if (poke && cyc == 5) begin
        cmd_valid = 1'b1; cmd_op = ~op; cmd_a = ~a; cmd_b = b + 7;
        hi_rd_req = 1'b1; lo_rd_req = 1'b1;
        #1;
        check(!hi_rd_ack && !lo_rd_ack, "R9_held_off", {hi_rd_ack, lo_rd_ack}, 0);
      end
      if (poke && cyc == 9) begin
        cmd_valid = 1'b0; hi_rd_req = 1'b0; lo_rd_req = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    check(cyc == W + 1, "R7_busy_len", cyc, W + 1);
    read_both(poke ? "R8" : op_tag(op, b), eh, el);
  endtask

  function automatic logic [W-1:0] pick();
    case ($urandom_range(0, 9))
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return W'($urandom_range(0, 20));
      default: return $urandom();
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_a = '0; cmd_b = '0;
    hi_rd_req = 1'b0; lo_rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy && cmd_ready, "R1_idle", {busy, cmd_ready}, 2'b01);
    read_both("R1", '0, '0);

    // directed corners
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);  // R2
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0);  // R3
    run_op(2'b00, 32'hFFFF_FFFF, 32'd7, 0);          // R3
    run_op(2'b11, 32'd100, 32'd7, 0);                // R4
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0);          // R5: -7/2
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0);          // R5: 7/-2
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);  // R5 overflow case
    run_op(2'b11, 32'h1234_5678, 32'd0, 0);          // R6
    run_op(2'b10, 32'h1234_5678, 32'd0, 0);          // R6
    run_op(2'b10, 32'hFFFF_FF00, 32'd0, 0);          // R6
    // R10: repeat reads without a new op
    read_both("R10", 32'hFFFF_FF00, 32'd1);
    read_both("R10", 32'hFFFF_FF00, 32'd1);
    // R8: conflicting command while busy
    run_op(2'b00, 32'hDEAD_BEEF, 32'h0000_1234, 1);
    run_op(2'b11, 32'hFFFF_0000, 32'd3, 1);

    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      logic [W-1:0] a, b;
      op = 2'($urandom_range(0, 3));
      a = pick();
      b = pick();
      run_op(op, a, b, (i % 25) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule